// File: doc/BRIEF.md
# Serial Lane Front End for a Byte-Wide ROM

This block lets a single byte-wide parallel ROM stand in for eight independent one-bit serial ROMs. A free-running address counter steps through the ROM one location per rising edge of the serial clock. Each byte read back holds one bit of each of eight interleaved serial streams. A fixed lane select picks which of those eight streams is driven onto the serial data output.

A host that bootstraps from a serial ROM sees an ordinary bitstream. The lane select, normally tied off by board straps, decides which of the eight stored images that host receives. Each stream is one bit wide and as deep as the ROM, which is 65536 bits at the default size. When the counter runs past the last location it returns to location zero without any sign, so an over-long read gets the start of the stream again.

Top module: `serial_lane_rom_bridge`

## Requirements
- R1: While `rst_n` is low, `rom_addr` is 0, and the clear takes effect at once, without waiting for a clock edge.
- R2: Once `rst_n` rises, `rom_addr` stays at 0 across the next two rising edges of `clk`. It first moves on the third rising edge.
- R3: Once running, `rom_addr` goes up by exactly one on every rising edge of `clk`.
- R4: After address 0xFFFF the counter returns to 0x0000 with no indication, so serial bit number 65536+k equals serial bit number k.
- R5: `sdo` equals bit `lane_sel` of `rom_data`. Lane 0 is the least significant bit and lane 7 is the most significant bit.
- R6: `sdo` is derived combinationally from the byte at the current `rom_addr`, before that address increments. The first serial bit after reset comes from address 0.
- R7: Changing `lane_sel` alters `sdo` within the same clock period and has no effect on `rom_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; the address advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lane_sel | input | 3 | Static choice of serial stream (0 = least significant data bit) |
| rom_addr | output | 16 | Address to the parallel ROM |
| rom_data | input | 8 | Byte returned by the ROM for `rom_addr` |
| sdo | output | 1 | Serial data bit of the selected stream |

## Verification
The ROM contents are a computed byte function of the address, chosen so that neighbouring lanes and neighbouring addresses differ often. A wrong bit order or an off-by-one address therefore shows up within a few cycles. One unbroken sweep covers every address and continues past the wrap. During the sweep the lane changes every 4096 cycles, which covers all eight lanes and checks that the bit after 0xFFFF matches the bit at address 0. A separate pattern changes the lane between clock edges, to show that the output follows the lane at once while the address holds. An asynchronous reset in the middle of a run, followed by the release sequence, separates the immediate clear from the two-cycle synchronised start.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int unsigned ROM_ADDR_W = 16;
  localparam int unsigned ROM_DATA_W = 8;
  localparam int unsigned LANE_SEL_W = $clog2(ROM_DATA_W);
  localparam int unsigned RST_STAGES = 2;

  typedef logic [ROM_ADDR_W-1:0] rom_addr_t;
  typedef logic [ROM_DATA_W-1:0] rom_byte_t;
  typedef logic [LANE_SEL_W-1:0] lane_t;
endpackage

// File: rtl/srl_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module srl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign run_n = chain_q[STAGES-1];
endmodule

// File: rtl/srl_addr_ctr.sv
// Wrapping address counter: next-state logic and register kept apart.
module srl_addr_ctr #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  output logic [WIDTH-1:0] addr
);
  logic [WIDTH-1:0] addr_q;
  logic [WIDTH-1:0] addr_d;

  // Natural modulo-2^WIDTH arithmetic gives the silent wrap.
  always_comb begin
    addr_d = addr_q;
    if (cnt_en) addr_d = addr_q + {{(WIDTH-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/srl_lane_mux.sv
// One-hot decode of the lane, then an AND-OR reduction over the byte.
module srl_lane_mux #(
  parameter int unsigned LANES = 8,
  localparam int unsigned SEL_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] data,
  input  logic [SEL_W-1:0] sel,
  output logic             bit_o
);
  logic [LANES-1:0] hot;
  logic [LANES-1:0] picked;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hot[g]    = (sel == SEL_W'(g));
    assign picked[g] = hot[g] & data[g];
  end

  assign bit_o = |picked;
endmodule

// File: rtl/serial_lane_rom_bridge.sv
module serial_lane_rom_bridge
  import srl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  lane_sel,
  output logic [15:0] rom_addr,
  input  logic [7:0]  rom_data,
  output logic        sdo
);
  logic run_n;

  srl_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .run_n (run_n)
  );

  srl_addr_ctr #(.WIDTH(ROM_ADDR_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (run_n),
    .addr   (rom_addr)
  );

  srl_lane_mux #(.LANES(ROM_DATA_W)) u_mux (
    .data  (rom_data),
    .sel   (lane_sel),
    .bit_o (sdo)
  );
endmodule

// File: rtl/serial_lane_rom_bridge_chk.sv
module serial_lane_rom_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run_n,
  input logic [2:0]  lane_sel,
  input logic [15:0] rom_addr,
  input logic [7:0]  rom_data,
  input logic        sdo
);
  // R2: the address stays at zero until the synchronised release.
  a_r2_hold_until_run: assert property (@(posedge clk) disable iff (!rst_n)
    !run_n |-> rom_addr == 16'h0000);

  // R3: exactly one step per clock once running.
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && $past(run_n) && $past(rom_addr) != 16'hFFFF)
      |-> rom_addr == $past(rom_addr) + 16'h0001);

  // R4: silent return to zero after the last location.
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && $past(run_n) && $past(rom_addr) == 16'hFFFF)
      |-> rom_addr == 16'h0000);

  // R5: with the lane and the byte unchanged, the serial bit cannot change.
  a_r5_out_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(lane_sel) && $stable(rom_data)) |-> $stable(sdo));
endmodule

bind serial_lane_rom_bridge serial_lane_rom_bridge_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_n    (run_n),
  .lane_sel (lane_sel),
  .rom_addr (rom_addr),
  .rom_data (rom_data),
  .sdo      (sdo)
);

// File: tb/serial_lane_rom_bridge_tb_top.sv
`timescale 1ns/1ps
module serial_lane_rom_bridge_tb_top;
  logic        clk;
  logic        rst_n;
  logic [2:0]  lane_sel;
  logic [15:0] rom_addr;
  logic [7:0]  rom_data;
  logic        sdo;

  int n_checks;
  int n_fails;
  int cycles;
  bit done;

  function automatic logic [7:0] rom_fn(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd29) ^ 8'h5A ^ {a[0], a[7:1]};
  endfunction

  assign rom_data = rom_fn(rom_addr);

  serial_lane_rom_bridge dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_sel (lane_sel),
    .rom_addr (rom_addr),
    .rom_data (rom_data),
    .sdo      (sdo)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  // Releases reset at a falling edge and checks the two-cycle hold (R2).
  task automatic release_and_hold();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check(rom_addr == 16'h0, "R2", rom_addr, 0);
    end
  endtask

  initial begin
    n_checks = 0; n_fails = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0;
    lane_sel = 3'd0;

    // R1: reset holds the address at zero.
    repeat (3) begin
      @(negedge clk);
      check(rom_addr == 16'h0, "R1", rom_addr, 0);
    end
    // R6: first serial bit comes from address 0.
    check(sdo == rom_fn(16'h0)[0], "R6", sdo, rom_fn(16'h0)[0]);

    release_and_hold();

    // Full sweep past the wrap; lane changes every 4096 addresses.
    for (int k = 1; k <= 65536 + 300; k++) begin
      @(negedge clk);
      begin
        logic [15:0] ea;
        logic [2:0]  ln;
        ea = k[15:0];
        check(rom_addr == ea, (k >= 65536) ? "R4" : "R3", rom_addr, ea);
        ln = 3'(k >> 12);
        lane_sel = ln;
        #0.5;
        check(sdo == rom_fn(ea)[ln], "R5", sdo, rom_fn(ea)[ln]);
        if (k == 65536)
          check(sdo == rom_fn(16'h0)[ln], "R4", sdo, rom_fn(16'h0)[ln]);
      end
    end

    // R7: lane change between edges, address untouched.
    @(negedge clk);
    begin
      logic [15:0] held;
      held = rom_addr;
      for (int l = 7; l >= 0; l--) begin
        lane_sel = 3'(l);
        #0.3;
        check(sdo == rom_fn(held)[l], "R7", sdo, rom_fn(held)[l]);
        check(rom_addr == held, "R7", rom_addr, held);
      end
    end

    // R1: asynchronous clear in mid period.
    @(posedge clk);
    #1.0;
    rst_n = 1'b0;
    #0.5;
    check(rom_addr == 16'h0, "R1", rom_addr, 0);
    lane_sel = 3'd6;
    release_and_hold();
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      check(rom_addr == 16'(k), "R3", rom_addr, k);
      check(sdo == rom_fn(16'(k))[6], "R6", sdo, rom_fn(16'(k))[6]);
    end

    finish_run();
  end
endmodule